// File: doc/BRIEF.md
# Prescaled Clock Timer with Periodic Interrupts

The block counts a slow count clock (nominally 256 Hz) with a binary up-counter. Each counter bit is a square wave at half the rate of the bit below it: bit 0 at 128 Hz and the top bit at 1 Hz. Software reads the counter through a small register interface. Four periodic interrupt sources are taken from counter taps at 32 Hz, 8 Hz, 2 Hz and 1 Hz. Each source has its own sticky flag and its own enable bit. A single level-sensitive interrupt line is raised while any enabled flag is set.

The count clock arrives asynchronously on `tick_in`. It is resynchronized into the bus clock, and its edges are turned into single-cycle events. A rising edge advances the counter. A falling edge is the only point at which a change to the run-enable bit takes effect. When the timer is stopped it adds one extra count before halting. The run-enable bit keeps reading as 1 until the counter has really halted.

Top module: `clock_timer`

## Requirements
- R1: While running, the counter advances by exactly one on each rising edge of `tick_in`, wrapping from all ones to zero.
- R2: Register addresses (read and write): 0 = control (bit 0 run enable, bit 1 soft reset), 1 = counter value (read only), 2 = flags, 3 = interrupt enables. Flag and enable bit 0 = 32 Hz, bit 1 = 8 Hz, bit 2 = 2 Hz, bit 3 = 1 Hz.
- R3: Writing 1 to the run-enable bit starts counting only at the next falling edge of `tick_in`; a rising edge before that falling edge does not count.
- R4: After 0 is written to the run-enable bit, counting continues until the next falling edge. Exactly one more rising edge is then counted, and after that the counter holds.
- R5: Control bit 0 reads 1 from a write of 1 until the counter has actually stopped, including during the stopping sequence of R4. It reads 0 once stopped.
- R6: A flag is set when its tap bit falls from 1 to 0 on a count: 32 Hz on counter bit 2 (every 8 counts), 8 Hz on bit 4 (every 32), 2 Hz on bit 6 (every 128) and 1 Hz on bit 7 (every 256).
- R7: Writing 1 to a flag bit clears it; writing 0 leaves it unchanged.
- R8: `irq` is high exactly while some flag and its matching enable bit are both set.
- R9: Writing 1 to control bit 1 clears the counter, all flags, the run-enable bit and the run state, and leaves the interrupt enables unchanged. Control bit 1 always reads 0.
- R10: After `rst_n` is asserted, all registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Asynchronous count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit counter and a two-stage synchronizer. With this width a full counter wrap takes only 256 count-clock periods, so every tap, including the 1 Hz source on the top bit, fires within the run. The count clock is driven as slow half-periods of several bus cycles each. This makes it possible to place register writes precisely between rising and falling edges and to check the start and stop sequences edge by edge.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int NSRC = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LAST = 2'd2
  } run_st_t;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_COUNT = 2'd1,
    RA_FLAG  = 2'd2,
    RA_IE    = 2'd3
  } reg_addr_t;

  // source index -> counter bit whose falling edge marks one period
  function automatic int tap_bit(input int cnt_w, input int src);
    case (src)
      0:       return cnt_w - 6;
      1:       return cnt_w - 4;
      2:       return cnt_w - 2;
      default: return cnt_w - 1;
    endcase
  endfunction

  // the tap bit falls on the next increment when all bits up to it are ones
  function automatic logic tap_wraps(input logic [31:0] val, input int bit_i);
    logic [31:0] mask;
    mask = (32'd1 << (bit_i + 1)) - 32'd1;
    return (val & mask) == mask;
  endfunction
endpackage

// File: rtl/ct_tick_sync.sv
module ct_tick_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic rise,
  output logic fall
);
  logic [SYNC_N-1:0] sh;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_N-2:0], tick_async};
      last <= sh[SYNC_N-1];
    end
  end

  assign rise = sh[SYNC_N-1] & ~last;
  assign fall = ~sh[SYNC_N-1] & last;

  // an edge event lasts one cycle (R1: one count per rising edge)
  p_one_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ct_runctl.sv
module ct_runctl
  import ct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic fall,
  input  logic en,
  input  logic sw_rst,
  output logic active,
  output logic step
);
  run_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else if (sw_rst) begin
      st <= ST_IDLE;
    end else if (fall) begin
      case (st)
        ST_IDLE: if (en)  st <= ST_RUN;
        ST_RUN:  if (!en) st <= ST_LAST;
        default: st <= st;
      endcase
    end else if (rise && st == ST_LAST) begin
      st <= ST_IDLE;
    end
  end

  assign active = (st != ST_IDLE);
  assign step   = rise & active;

  // R3: leaving idle happens only on a falling edge
  p_start_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !fall) |=> st == ST_IDLE);
  // R4: the extra count ends the stopping sequence
  p_last_then_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAST && rise) |=> st == ST_IDLE);
endmodule

// File: rtl/ct_counter.sv
module ct_counter
  import ct_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic [NSRC-1:0]  tap_fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_tap
    assign tap_fall[i] = step & tap_wraps(32'(cnt), tap_bit(CNT_W, i));
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> cnt == $past(cnt) + 1'b1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(cnt));
endmodule

// File: rtl/ct_irq.sv
module ct_irq
  import ct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_ev,
  input  logic [NSRC-1:0] clr,
  input  logic            ie_wr,
  input  logic [NSRC-1:0] ie_data,
  input  logic            sw_rst,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] ie,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ie    <= '0;
    end else begin
      if (sw_rst) flags <= '0;
      else        flags <= (flags & ~clr) | set_ev;  // a new event wins
      if (ie_wr)  ie <= ie_data;
    end
  end

  assign irq = |(flags & ie);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> (flags & $past(clr & ~set_ev)) == '0);
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0 && set_ev == '0 && !sw_rst) |=> $stable(flags));
  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |-> !irq);
endmodule

// File: rtl/clock_timer.sv
module clock_timer
  import ct_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic            rise, fall, active, step;
  logic            en_reg, wr_ctrl, sw_rst;
  logic [CNT_W-1:0] cnt;
  logic [NSRC-1:0] tap_fall, flags, ie, clr;

  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);
  assign sw_rst  = wr_ctrl && wr_data[1];
  assign clr     = (wr_en && wr_addr == RA_FLAG) ? wr_data[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_reg <= 1'b0;
    else if (sw_rst)  en_reg <= 1'b0;
    else if (wr_ctrl) en_reg <= wr_data[0];
  end

  ct_tick_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_async(tick_in), .rise(rise), .fall(fall));

  ct_runctl u_run (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .en(en_reg),
    .sw_rst(sw_rst), .active(active), .step(step));

  ct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(sw_rst),
    .cnt(cnt), .tap_fall(tap_fall));

  ct_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(tap_fall), .clr(clr),
    .ie_wr(wr_en && wr_addr == RA_IE), .ie_data(wr_data[NSRC-1:0]),
    .sw_rst(sw_rst), .flags(flags), .ie(ie), .irq(irq));

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL:  rd_data[0] = en_reg | active;
      RA_COUNT: rd_data = cnt;
      RA_FLAG:  rd_data[NSRC-1:0] = flags;
      default:  rd_data[NSRC-1:0] = ie;
    endcase
  end

  p_swrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (cnt == '0 && flags == '0 && !active));
  p_rb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_addr == RA_CTRL) |-> rd_data[0]);
endmodule

// File: tb/sim_clock_timer.sv
module sim_clock_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  clock_timer u0 (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a; #1; d = int'(rd_data);
  endtask

  task automatic rise_h(); @(negedge clk); tick_in = 1'b1; repeat (6) @(negedge clk); endtask
  task automatic fall_h(); @(negedge clk); tick_in = 1'b0; repeat (6) @(negedge clk); endtask
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin rise_h(); fall_h(); end
  endtask

  task automatic t_reset();
    int d;
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); check("R10 reg", d, 0); end
    check("R10 irq", int'(irq), 0);
  endtask

  task automatic t_start();
    int d;
    wr(2'd0, 8'h01);
    rise_h(); rd(2'd1, d); check("R3 no count before fall", d, 0);
    fall_h(); pulses(1); rd(2'd1, d); check("R1 first count", d, 1);
    pulses(6); rd(2'd2, d); check("R6 no flag at 7", d, 0);
    pulses(1); rd(2'd2, d); check("R6 32Hz at 8", d, 1);
    rd(2'd0, d); check("R2 ctrl enable", d, 1);
  endtask

  task automatic t_irq_w1c();
    int d;
    check("R8 masked", int'(irq), 0);
    wr(2'd3, 8'h01); check("R8 enabled", int'(irq), 1);
    wr(2'd3, 8'h02); check("R8 other enable", int'(irq), 0);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h0E); rd(2'd2, d); check("R7 write 0 keeps", d, 1);
    wr(2'd2, 8'h01); rd(2'd2, d); check("R7 write 1 clears", d, 0);
    check("R8 drops", int'(irq), 0);
  endtask

  task automatic t_taps();
    int d;
    pulses(24); rd(2'd1, d); check("R1 count 32", d, 32);
    rd(2'd2, d); check("R6 8Hz at 32", d, 3);
    wr(2'd2, 8'h0F);
    pulses(96); rd(2'd2, d); check("R6 2Hz at 128", d, 7);
    wr(2'd2, 8'h0F);
    pulses(128); rd(2'd1, d); check("R1 wrap", d, 0);
    rd(2'd2, d); check("R6 1Hz at 256", d, 15);
  endtask

  task automatic t_stop();
    int d;
    wr(2'd0, 8'h00); rd(2'd0, d); check("R5 still 1 after write", d, 1);
    rise_h(); rd(2'd1, d); check("R4 counts before fall", d, 1);
    fall_h(); rd(2'd0, d); check("R5 still 1 while stopping", d, 1);
    rise_h(); rd(2'd1, d); check("R4 extra count", d, 2);
    rd(2'd0, d); check("R5 reads 0 once stopped", d, 0);
    fall_h(); pulses(2); rd(2'd1, d); check("R4 holds", d, 2);
  endtask

  task automatic t_swrst();
    int d;
    wr(2'd3, 8'h05); wr(2'd0, 8'h01);
    pulses(9); rd(2'd1, d); check("R3 restart", d, 10);
    check("R8 irq before reset", int'(irq), 1);
    wr(2'd0, 8'h02);
    rd(2'd1, d); check("R9 count cleared", d, 0);
    rd(2'd2, d); check("R9 flags cleared", d, 0);
    rd(2'd0, d); check("R9 ctrl reads 0", d, 0);
    rd(2'd3, d); check("R9 enables kept", d, 5);
    check("R9 irq low", int'(irq), 0);
    pulses(2); rd(2'd1, d); check("R9 stopped", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_irq_w1c();
    t_taps();
    t_stop();
    t_swrst();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule